// File: doc/BRIEF.md
# Packet VM Integer ALU Execute Stage

This block is the integer execute stage of a small 64-bit register-machine core of the kind used to run sandboxed packet-processing programs. Each accepted request carries an 8-bit opcode, the current destination operand, a source register operand and a 32-bit immediate. The block returns the value to write back to the destination, with a one-cycle valid strobe. A flag marks opcodes it cannot decode.

The opcode's three low bits pick one of two operand widths. One width works on the low halves and clears the upper half of the result. The other works on the full 64 bits. Bit 3 picks the second operand: either the source register or the sign-extended immediate. The upper nibble names the operation. Most operations finish one cycle after acceptance. Unsigned division and remainder with a non-zero divisor run on a bit-serial unit. While that unit runs, `busy` is high and new requests are ignored. A zero divisor is resolved at once and never starts the serial unit.

Top module: `pvm_alu_exec`

## Requirements
- R1: Opcode bits [2:0] select the width: 0x4 is the 32-bit class and 0x7 is the 64-bit class. Any other class value sets `illegal` and `out_valid` one cycle after acceptance, and `result` equals the accepted `dst_in`.
- R2: Opcode bit 3 selects the second operand. When it is 1, the second operand is `src_in`. When it is 0, the second operand is `imm`, sign-extended to 64 bits.
- R3: In the 32-bit class, the operation uses the low 32 bits of both operands, and `result[63:32]` is zero. The one exception is remainder by zero (R7).
- R4: Opcode bits [7:4] select the operation: 0x0 add, 0x1 subtract, 0x2 multiply (low bits kept), 0x4 or, 0x5 and, 0x6 left shift, 0x7 logical right shift, 0x8 negate destination, 0xa xor, 0xb move operand, 0xc arithmetic right shift. Shift counts use the low 6 bits of the operand in the 64-bit class and the low 5 bits in the 32-bit class. These operations give `out_valid` one cycle after acceptance.
- R5: Code 0x3 (quotient) and code 0x9 (remainder) are unsigned. With a non-zero divisor, `busy` is high from the cycle after acceptance until the cycle in which `out_valid` rises. `out_valid` stays low while `busy` is high.
- R6: A quotient with a zero divisor gives a result of 0 one cycle after acceptance, and `busy` stays low.
- R7: A remainder with a zero divisor gives the full 64-bit accepted `dst_in`, in either class, one cycle after acceptance, and `busy` stays low.
- R8: Operation codes 0xd, 0xe and 0xf are illegal in both classes. They behave as in R1.
- R9: A request presented while `busy` is high is ignored. No extra `out_valid` appears, and the pending division result is unaffected. This includes a request presented in the last busy cycle.
- R10: Synchronous active-high reset drives `out_valid`, `illegal` and `busy` low and `result` to zero.
- R11: Each accepted request produces exactly one single-cycle `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; accepted when `busy` is low |
| opcode | input | 8 | Operation, operand select and width class |
| dst_in | input | 64 | Current destination value |
| src_in | input | 64 | Source register value |
| imm | input | 32 | Immediate operand |
| busy | output | 1 | Serial divider occupied; requests ignored |
| out_valid | output | 1 | One-cycle strobe marking `result` valid |
| illegal | output | 1 | Opcode not decodable; qualifies `out_valid` |
| result | output | 64 | New destination value |

## Verification
Two events can meet in one cycle: a serial division finishing and a new request arriving. This is the only case where two writers compete for the output register. The bench provokes it by holding a second request on `in_valid` for the whole busy window, including the final busy cycle. It then checks for exactly one `out_valid` pulse, carrying the division's quotient, and no pulse for the held request. A full sweep of all 256 opcodes against several operand sets covers the remaining paths: the fast operations, the illegal opcodes and the zero-divisor shortcuts.

// File: rtl/pvm_alu_pkg.sv
package pvm_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_SUB  = 4'h1,
    OP_MUL  = 4'h2,
    OP_DIV  = 4'h3,
    OP_OR   = 4'h4,
    OP_AND  = 4'h5,
    OP_SHL  = 4'h6,
    OP_SHR  = 4'h7,
    OP_NEG  = 4'h8,
    OP_MOD  = 4'h9,
    OP_XOR  = 4'ha,
    OP_MOV  = 4'hb,
    OP_SAR  = 4'hc,
    OP_BAD  = 4'hf
  } alu_op_e;

  localparam logic [2:0] CLASS_W32 = 3'h4;
  localparam logic [2:0] CLASS_W64 = 3'h7;

endpackage

// File: rtl/pvm_alu_decode.sv
module pvm_alu_decode
  import pvm_alu_pkg::*;
(
  input  logic [7:0] opcode,
  output alu_op_e    op,
  output logic       wide,
  output logic       use_reg,
  output logic       bad
);
  logic [2:0] cls;
  logic       cls_ok;

  assign cls     = opcode[2:0];
  assign use_reg = opcode[3];
  assign wide    = (cls == CLASS_W64);
  assign cls_ok  = (cls == CLASS_W64) || (cls == CLASS_W32);

  always_comb begin
    unique case (opcode[7:4])
      4'h0: op = OP_ADD;
      4'h1: op = OP_SUB;
      4'h2: op = OP_MUL;
      4'h3: op = OP_DIV;
      4'h4: op = OP_OR;
      4'h5: op = OP_AND;
      4'h6: op = OP_SHL;
      4'h7: op = OP_SHR;
      4'h8: op = OP_NEG;
      4'h9: op = OP_MOD;
      4'ha: op = OP_XOR;
      4'hb: op = OP_MOV;
      4'hc: op = OP_SAR;
      default: op = OP_BAD;
    endcase
  end

  assign bad = !cls_ok || (op == OP_BAD);
endmodule

// File: rtl/pvm_alu_fast.sv
module pvm_alu_fast
  import pvm_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  alu_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  localparam int HALF_W = DATA_W / 2;
  localparam int SH_W   = $clog2(DATA_W);

  logic [HALF_W-1:0] a_lo, b_lo, y_lo;
  logic [DATA_W-1:0] y_full;
  logic [SH_W-1:0]   sh_full;
  logic [SH_W-2:0]   sh_half;
  logic              b_zero_full, b_zero_half;

  assign a_lo        = a[HALF_W-1:0];
  assign b_lo        = b[HALF_W-1:0];
  assign sh_full     = b[SH_W-1:0];
  assign sh_half     = b[SH_W-2:0];
  assign b_zero_full = (b == '0);
  assign b_zero_half = (b_lo == '0);

  // Full-width path; quotient/remainder entries only cover a zero divisor.
  always_comb begin
    unique case (op)
      OP_ADD:  y_full = a + b;
      OP_SUB:  y_full = a - b;
      OP_MUL:  y_full = a * b;
      OP_OR:   y_full = a | b;
      OP_AND:  y_full = a & b;
      OP_SHL:  y_full = a << sh_full;
      OP_SHR:  y_full = a >> sh_full;
      OP_NEG:  y_full = -a;
      OP_XOR:  y_full = a ^ b;
      OP_MOV:  y_full = b;
      OP_SAR:  y_full = DATA_W'($signed(a) >>> sh_full);
      OP_DIV:  y_full = '0;
      OP_MOD:  y_full = a;
      default: y_full = a;
    endcase
  end

  always_comb begin
    unique case (op)
      OP_ADD:  y_lo = a_lo + b_lo;
      OP_SUB:  y_lo = a_lo - b_lo;
      OP_MUL:  y_lo = a_lo * b_lo;
      OP_OR:   y_lo = a_lo | b_lo;
      OP_AND:  y_lo = a_lo & b_lo;
      OP_SHL:  y_lo = a_lo << sh_half;
      OP_SHR:  y_lo = a_lo >> sh_half;
      OP_NEG:  y_lo = -a_lo;
      OP_XOR:  y_lo = a_lo ^ b_lo;
      OP_MOV:  y_lo = b_lo;
      OP_SAR:  y_lo = HALF_W'($signed(a_lo) >>> sh_half);
      default: y_lo = '0;
    endcase
  end

  // Remainder by zero keeps the whole destination in either width.
  always_comb begin
    if (wide) begin
      y = y_full;
    end else if (op == OP_MOD && b_zero_half) begin
      y = a;
    end else begin
      y = {{(DATA_W-HALF_W){1'b0}}, y_lo};
    end
  end

  // Flags are informational only for the zero-divisor selection above.
  logic unused_ok;
  assign unused_ok = b_zero_full;
endmodule

// File: rtl/pvm_alu_serdiv.sv
module pvm_alu_serdiv #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CNT_W = $clog2(W + 1);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     dvs;
  logic [W:0]       trial;
  logic             fits;

  assign trial = {rem, quot[W-1]};
  assign fits  = (trial >= {1'b0, dvs});

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      dvs     <= '0;
      quot    <= '0;
      rem     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !running) begin
        running <= 1'b1;
        cnt     <= CNT_W'(W);
        dvs     <= divisor;
        quot    <= dividend;
        rem     <= '0;
      end else if (running) begin
        rem  <= fits ? W'(trial - {1'b0, dvs}) : trial[W-1:0];
        quot <= {quot[W-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  // Completion cycle still counts as busy so no new request lands on it.
  assign busy = running || done;
endmodule

// File: rtl/pvm_alu_exec.sv
module pvm_alu_exec
  import pvm_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  input  logic [IMM_W-1:0]  imm,
  output logic              busy,
  output logic              out_valid,
  output logic              illegal,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op;
  logic              wide, use_reg, bad;
  logic [DATA_W-1:0] opnd_b, fast_y;
  logic [DATA_W-1:0] div_a, div_b, quot, rem;
  logic              is_divmod, divisor_zero, accept, div_start, div_done;
  logic              pend_mod;

  pvm_alu_decode u_dec (
    .opcode  (opcode),
    .op      (op),
    .wide    (wide),
    .use_reg (use_reg),
    .bad     (bad)
  );

  assign opnd_b = use_reg ? src_in : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  pvm_alu_fast #(.DATA_W(DATA_W)) u_fast (
    .op   (op),
    .wide (wide),
    .a    (dst_in),
    .b    (opnd_b),
    .y    (fast_y)
  );

  assign div_a        = wide ? dst_in : {{(DATA_W-HALF_W){1'b0}}, dst_in[HALF_W-1:0]};
  assign div_b        = wide ? opnd_b : {{(DATA_W-HALF_W){1'b0}}, opnd_b[HALF_W-1:0]};
  assign is_divmod    = (op == OP_DIV) || (op == OP_MOD);
  assign divisor_zero = (div_b == '0);
  assign accept       = in_valid && !busy;
  assign div_start    = accept && !bad && is_divmod && !divisor_zero;

  pvm_alu_serdiv #(.W(DATA_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (div_a),
    .divisor  (div_b),
    .busy     (busy),
    .done     (div_done),
    .quot     (quot),
    .rem      (rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
      pend_mod  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      illegal   <= 1'b0;
      if (div_done) begin
        out_valid <= 1'b1;
        result    <= pend_mod ? rem : quot;
      end else if (div_start) begin
        pend_mod  <= (op == OP_MOD);
      end else if (accept) begin
        out_valid <= 1'b1;
        illegal   <= bad;
        result    <= bad ? dst_in : fast_y;
      end
    end
  end
endmodule

// File: rtl/pvm_alu_exec_chk.sv
module pvm_alu_exec_chk #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [7:0]        opcode,
  input logic [DATA_W-1:0] dst_in,
  input logic [DATA_W-1:0] src_in,
  input logic [IMM_W-1:0]  imm,
  input logic              busy,
  input logic              out_valid,
  input logic              illegal,
  input logic [DATA_W-1:0] result
);
  localparam int HALF_W = DATA_W / 2;

  logic take, cls_bad, reg64;
  assign take    = in_valid && !busy;
  assign cls_bad = (opcode[2:0] != 3'h4) && (opcode[2:0] != 3'h7);
  assign reg64   = (opcode[3:0] == 4'hf);

  a_r10_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !busy && !illegal && result == '0));

  a_r1_bad_class: assert property (@(posedge clk) disable iff (rst)
    (take && cls_bad) |=> (out_valid && illegal && result == $past(dst_in)));

  a_r3_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (take && opcode[2:0] == 3'h4 && opcode[7:4] <= 4'hc &&
     opcode[7:4] != 4'h3 && opcode[7:4] != 4'h9)
    |=> (out_valid && result[DATA_W-1:HALF_W] == '0));

  a_r5_busy_blocks_valid: assert property (@(posedge clk) disable iff (rst)
    busy |-> !out_valid);

  a_r5_busy_starts: assert property (@(posedge clk) disable iff (rst)
    (take && reg64 && (opcode[7:4] == 4'h3 || opcode[7:4] == 4'h9) && src_in != '0)
    |=> (busy && !out_valid));

  a_r6_div_zero: assert property (@(posedge clk) disable iff (rst)
    (take && reg64 && opcode[7:4] == 4'h3 && src_in == '0)
    |=> (out_valid && !busy && result == '0));

  a_r7_mod_zero: assert property (@(posedge clk) disable iff (rst)
    (take && reg64 && opcode[7:4] == 4'h9 && src_in == '0)
    |=> (out_valid && !busy && result == $past(dst_in)));

  a_r1_illegal_qualified: assert property (@(posedge clk) disable iff (rst)
    illegal |-> out_valid);

  logic unused_ok;
  assign unused_ok = ^imm;
endmodule

bind pvm_alu_exec pvm_alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .opcode    (opcode),
  .dst_in    (dst_in),
  .src_in    (src_in),
  .imm       (imm),
  .busy      (busy),
  .out_valid (out_valid),
  .illegal   (illegal),
  .result    (result)
);

// File: tb/pvm_alu_exec_test.sv
module pvm_alu_exec_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dst_in = '0, src_in = '0;
  logic [31:0] imm = '0;
  logic        busy, out_valid, illegal;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  pvm_alu_exec uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .dst_in(dst_in), .src_in(src_in), .imm(imm),
    .busy(busy), .out_valid(out_valid), .illegal(illegal), .result(result)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s op=%02h actual=%h expected=%h", tag, opcode, act, exp);
    end
  endtask

  // Independent reference built from the requirement text.
  function automatic logic [64:0] model(input logic [7:0] op, input logic [63:0] d,
                                        input logic [63:0] s, input logic [31:0] i);
    logic [63:0] b, r;
    logic [31:0] a32, b32, r32;
    int code;
    int cls;
    code = op[7:4];
    cls  = op[2:0];
    if ((cls != 4 && cls != 7) || code > 12) return {1'b1, d};
    b   = op[3] ? s : {{32{i[31]}}, i};
    a32 = d[31:0];
    b32 = b[31:0];
    if (cls == 7) begin
      case (code)
        0: r = d + b;   1: r = d - b;   2: r = d * b;
        3: r = (b == 0) ? 64'd0 : d / b;
        4: r = d | b;   5: r = d & b;   6: r = d << b[5:0];
        7: r = d >> b[5:0];             8: r = 64'd0 - d;
        9: r = (b == 0) ? d : d % b;
        10: r = d ^ b;  11: r = b;
        default: r = 64'($signed(d) >>> b[5:0]);
      endcase
      return {1'b0, r};
    end
    if (code == 9 && b32 == 0) return {1'b0, d};
    case (code)
      0: r32 = a32 + b32;  1: r32 = a32 - b32;  2: r32 = a32 * b32;
      3: r32 = (b32 == 0) ? 32'd0 : a32 / b32;
      4: r32 = a32 | b32;  5: r32 = a32 & b32;  6: r32 = a32 << b32[4:0];
      7: r32 = a32 >> b32[4:0];                 8: r32 = 32'd0 - a32;
      9: r32 = a32 % b32;
      10: r32 = a32 ^ b32; 11: r32 = b32;
      default: r32 = 32'($signed(a32) >>> b32[4:0]);
    endcase
    return {1'b0, 32'd0, r32};
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic [63:0] s, input logic [31:0] i);
    logic [63:0] b;
    b = op[3] ? s : {{32{i[31]}}, i};
    if (op[2:0] != 3'h4 && op[2:0] != 3'h7) return "R1";
    if (op[7:4] > 4'hc) return "R8";
    if (op[7:4] == 4'h3 || op[7:4] == 4'h9) begin
      if ((op[2:0] == 3'h7 && b == 0) || (op[2:0] == 3'h4 && b[31:0] == 0))
        return (op[7:4] == 4'h3) ? "R6" : "R7";
      return "R5";
    end
    if (op[2:0] == 3'h4) return "R3";
    return op[3] ? "R4" : "R2";
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [63:0] d,
                        input logic [63:0] s, input logic [31:0] i);
    logic [64:0] e;
    string t;
    int waited;
    e = model(op, d, s, i);
    t = tag_of(op, s, i);
    @(negedge clk);
    opcode = op; dst_in = d; src_in = s; imm = i; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (t == "R5") begin
      check("R5", {63'd0, busy}, 64'd1);
      waited = 0;
      while (!out_valid && waited < 200) begin
        @(negedge clk);
        waited++;
      end
      check("R5", {63'd0, busy}, 64'd0);
    end else begin
      check("R11", {63'd0, out_valid}, 64'd1);
      check(t, {63'd0, busy}, 64'd0);
    end
    check(t, result, e[63:0]);
    check(t, {63'd0, illegal}, {63'd0, e[64]});
    @(negedge clk);
    check("R11", {63'd0, out_valid}, 64'd0);
  endtask

  logic [63:0] dset [4];
  logic [63:0] sset [4];
  logic [31:0] iset [4];

  initial begin
    dset[0] = 64'h0123_4567_89ab_cdef; sset[0] = 64'h5;                   iset[0] = 32'h3;
    dset[1] = 64'hffff_ffff_8000_0001; sset[1] = 64'h8000_0000_0000_0041; iset[1] = 32'hffff_fff0;
    dset[2] = 64'h7;                   sset[2] = 64'h0;                   iset[2] = 32'h0;
    dset[3] = 64'hfedc_ba98_7654_3210; sset[3] = 64'h0000_0001_0000_0000; iset[3] = 32'h8000_0000;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", {61'd0, out_valid, busy, illegal}, 64'd0);
    check("R10", result, 64'd0);
    rst = 1'b0;

    for (int k = 0; k < 4; k++) begin
      for (int op = 0; op < 256; op++) begin
        run_op(8'(op), dset[k], sset[k], iset[k]);
      end
    end

    // R9: a request held across the whole busy window, final busy cycle included.
    @(negedge clk);
    opcode = 8'h3f; dst_in = 64'd1000; src_in = 64'd7; imm = '0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    opcode = 8'h0f; dst_in = 64'd1; src_in = 64'd1;
    check("R9", {63'd0, busy}, 64'd1);
    for (int w = 0; w < 200 && !out_valid; w++) @(negedge clk);
    in_valid = 1'b0;
    check("R9", {63'd0, out_valid}, 64'd1);
    check("R9", result, 64'd142);
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule